// File: doc/BRIEF.md
# Serial Response Bit Realigner

A receiver that samples a serial response line on a free-running clock packs the samples into bytes, most significant bit first, without knowing where the response begins. The response starts with the first zero bit on the line, and that bit can fall at any position inside any of the leading bytes. This block consumes that byte stream as it arrives, finds the first zero bit inside a bounded search window, and emits the response re-packed so that the start bit sits in bit 7 of the first output byte. Each output byte is built from the tail of one captured byte and the head of the next, so the shift happens in real time with a single byte of lookahead and no buffering of the capture.

Input bytes arrive in fixed-length captures of `SEARCH_BYTES + OUT_BYTES` bytes. For each capture the block produces either `OUT_BYTES` realigned bytes, the last one flagged, or a single miss beat when the search window holds no zero. Every beat also carries the bit offset at which the start bit was found. Bytes of a capture that the response does not need are consumed and dropped, and the next byte begins a new capture.

Top module: `resp_bit_realign`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Capture bit i is bit (7 - i mod 8) of capture byte i/8. The start offset is the index i of the first zero bit, that is 8 times the byte index plus the number of ones above the first zero in that byte. It is reported on `out_offset` with every beat of a found response.
- R3: Output bit k of the response, which is bit (7 - k mod 8) of output byte k/8, equals capture bit k + offset. The first output byte therefore has bit 7 equal to 0.
- R4: Each capture is exactly `SEARCH_BYTES + OUT_BYTES` input bytes. Bytes after the response, or after a miss, are accepted and discarded, zero bits included. The byte that follows begins a fresh search.
- R5: A found response yields exactly `OUT_BYTES` beats. `out_last` is 1 on the final beat and 0 on the others.
- R6: If no zero bit lies in the first `SEARCH_BYTES` bytes (64 bit positions by default), the block emits one beat with `out_miss` = 1, `out_last` = 1, `out_data` = 8'hFF and `out_offset` = 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all output fields hold steady.
- R8: The output sequence does not depend on gaps in `in_valid` or on the pattern of `out_ready` stalls.
- R9: With `out_ready` held at 1, `in_ready` stays 1, so one byte is taken every cycle that `in_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Captured byte available |
| in_ready | output | 1 | Block accepts the captured byte this cycle |
| in_data | input | 8 | Captured byte, earliest sample in bit 7 |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 8 | Realigned response byte |
| out_last | output | 1 | Final beat of this capture's result |
| out_miss | output | 1 | No start bit found within the search window |
| out_offset | output | OFF_W (6) | Bit offset of the start bit |

## Verification
The hardest situation to reach is a stall that lands exactly while the lookahead byte is held and the merge is half done. At that point a lost or doubled input byte would shift every later output bit. The bench sweeps every one of the 64 start offsets in three traffic modes: free-flowing, random input gaps with random output stalls, and output mostly stalled. Each offset is therefore met with the stall at many different merge positions. Captures whose discarded tail is all zeros, and a miss followed by a normal capture, show that framing survives the stretches where a misaligned search would wrongly find a start bit.

// File: rtl/resp_realign_pkg.sv
// Shared definitions for the serial response bit realigner.
// Assumes byte-wide captures with the earliest sample in the top bit.
package resp_realign_pkg;

    localparam int BYTE_W = 8;
    localparam int POS_W  = $clog2(BYTE_W);

    // Sequencer phases within one capture
    typedef enum logic [1:0] {
        PH_SEEK  = 2'd0,   // hunting the first zero bit
        PH_MERGE = 2'd1,   // emitting realigned bytes
        PH_DRAIN = 2'd2    // discarding the rest of the capture
    } seq_phase_t;

endpackage

// File: rtl/rra_zero_scan.sv
// Finds the first zero bit of a byte counted from its top bit.
// Assumes the top bit is the earliest sample; pos is meaningless when found is 0.
module rra_zero_scan
    import resp_realign_pkg::*;
#(
    parameter int W  = BYTE_W,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    output logic          found,
    output logic [PW-1:0] pos
);

    // Priority pick: the lowest index from the top wins, so scan downward
    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!data[W-1-i]) pos = PW'(i);
        end
    end

    // Any zero bit present
    assign found = ~&data;

endmodule

// File: rtl/rra_funnel.sv
// Funnel shifter: takes the W bits starting sh bits below the top of {hi, lo}.
// Assumes hi is the older byte; sh = 0 returns hi unchanged.
module rra_funnel
    import resp_realign_pkg::*;
#(
    parameter int W  = BYTE_W,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  hi,
    input  logic [W-1:0]  lo,
    input  logic [SW-1:0] sh,
    output logic [W-1:0]  y
);

    logic [2*W-1:0] joined;
    logic [W-1:0]   cand [W];

    assign joined = {hi, lo};

    // One fixed window per shift amount
    for (genvar s = 0; s < W; s++) begin : g_win
        assign cand[s] = joined[2*W-1-s -: W];
    end

    // Select the window for the requested shift
    assign y = cand[sh];

endmodule

// File: rtl/rra_seq_ctrl.sv
// Capture sequencer: counts accepted bytes, latches the start offset,
// and tells the datapath when to emit a merged byte or a miss beat.
// Assumes every capture is SEARCH_BYTES + OUT_BYTES bytes long and that
// accept is only asserted when the output slot can take a beat.
module rra_seq_ctrl
    import resp_realign_pkg::*;
#(
    parameter int SEARCH_BYTES = 8,
    parameter int OUT_BYTES    = 6,
    localparam int CAP_BYTES   = SEARCH_BYTES + OUT_BYTES,
    localparam int CC_W        = $clog2(CAP_BYTES),
    localparam int EC_W        = $clog2(OUT_BYTES + 1),
    localparam int SB_W        = $clog2(SEARCH_BYTES),
    localparam int OFF_W       = SB_W + POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             zero_found,
    input  logic [POS_W-1:0] zero_pos,
    output logic             emit_byte,
    output logic             emit_miss,
    output logic             emit_last,
    output logic [OFF_W-1:0] offset,
    output logic [POS_W-1:0] shift
);

    seq_phase_t      ph_q, ph_d;
    logic [CC_W-1:0] cap_q;
    logic [EC_W-1:0] emit_q;
    logic [OFF_W-1:0] off_q;

    logic cap_end, seek_end, emit_end;

    assign cap_end  = (cap_q == CC_W'(CAP_BYTES - 1));
    assign seek_end = (cap_q == CC_W'(SEARCH_BYTES - 1));
    assign emit_end = (emit_q == EC_W'(OUT_BYTES - 1));

    // Next phase and emit strobes for the byte being accepted
    always_comb begin
        ph_d      = ph_q;
        emit_byte = 1'b0;
        emit_miss = 1'b0;
        emit_last = 1'b0;
        unique case (ph_q)
            PH_SEEK: begin
                if (accept) begin
                    if (zero_found) begin
                        ph_d = PH_MERGE;
                    end else if (seek_end) begin
                        emit_miss = 1'b1;
                        ph_d      = PH_DRAIN;
                    end
                end
            end
            PH_MERGE: begin
                if (accept) begin
                    emit_byte = 1'b1;
                    emit_last = emit_end;
                    if (emit_end) ph_d = cap_end ? PH_SEEK : PH_DRAIN;
                end
            end
            PH_DRAIN: begin
                if (accept && cap_end) ph_d = PH_SEEK;
            end
            default: ph_d = PH_SEEK;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_SEEK;
        else        ph_q <= ph_d;
    end

    // Byte position within the current capture, wrapping at its end
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (accept) cap_q <= cap_end ? '0 : cap_q + 1'b1;
    end

    // Count of response bytes emitted so far
    always_ff @(posedge clk) begin
        if (!rst_n)               emit_q <= '0;
        else if (ph_q == PH_SEEK) emit_q <= '0;
        else if (emit_byte)       emit_q <= emit_q + 1'b1;
    end

    // Start offset latched when the first zero is seen
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_q <= '0;
        else if (ph_q == PH_SEEK && accept && zero_found)
            off_q <= {cap_q[SB_W-1:0], zero_pos};
    end

    assign offset = off_q;
    assign shift  = off_q[POS_W-1:0];

endmodule

// File: rtl/resp_bit_realign.sv
// Serial response bit realigner, top level.
// Consumes fixed-length captures of MSB-first bytes, finds the first zero bit
// in the leading SEARCH_BYTES bytes and emits OUT_BYTES bytes shifted so the
// start bit lands in bit 7 of the first, or one miss beat when there is none.
// Assumes downstream obeys valid/ready; in_ready depends combinationally on out_ready.
module resp_bit_realign
    import resp_realign_pkg::*;
#(
    parameter int SEARCH_BYTES = 8,
    parameter int OUT_BYTES    = 6,
    localparam int OFF_W       = $clog2(SEARCH_BYTES) + POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              out_miss,
    output logic [OFF_W-1:0]  out_offset
);

    logic              accept;
    logic              zero_found;
    logic [POS_W-1:0]  zero_pos;
    logic              emit_byte, emit_miss, emit_last;
    logic [OFF_W-1:0]  offset;
    logic [POS_W-1:0]  shift;
    logic [BYTE_W-1:0] look_q;
    logic [BYTE_W-1:0] merged;

    logic              ov_q, ol_q, om_q;
    logic [BYTE_W-1:0] od_q;
    logic [OFF_W-1:0]  oo_q;

    // Accept a byte only when the single output slot is free or draining
    assign in_ready = !ov_q || out_ready;
    assign accept   = in_valid && in_ready;

    rra_zero_scan #(.W(BYTE_W)) u_scan (
        .data  (in_data),
        .found (zero_found),
        .pos   (zero_pos)
    );

    rra_seq_ctrl #(
        .SEARCH_BYTES (SEARCH_BYTES),
        .OUT_BYTES    (OUT_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .zero_found (zero_found),
        .zero_pos   (zero_pos),
        .emit_byte  (emit_byte),
        .emit_miss  (emit_miss),
        .emit_last  (emit_last),
        .offset     (offset),
        .shift      (shift)
    );

    rra_funnel #(.W(BYTE_W)) u_funnel (
        .hi (look_q),
        .lo (in_data),
        .sh (shift),
        .y  (merged)
    );

    // One-byte lookahead: the previously accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n)      look_q <= '1;
        else if (accept) look_q <= in_data;
    end

    // Output slot: loads a merged byte or a miss beat, clears when taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q <= 1'b0;
            od_q <= '0;
            ol_q <= 1'b0;
            om_q <= 1'b0;
            oo_q <= '0;
        end else if (emit_byte) begin
            ov_q <= 1'b1;
            od_q <= merged;
            ol_q <= emit_last;
            om_q <= 1'b0;
            oo_q <= offset;
        end else if (emit_miss) begin
            ov_q <= 1'b1;
            od_q <= '1;
            ol_q <= 1'b1;
            om_q <= 1'b1;
            oo_q <= '0;
        end else if (out_ready) begin
            ov_q <= 1'b0;
        end
    end

    assign out_valid  = ov_q;
    assign out_data   = od_q;
    assign out_last   = ol_q;
    assign out_miss   = om_q;
    assign out_offset = oo_q;

endmodule

// File: rtl/resp_bit_realign_chk.sv
// Protocol and framing checker for resp_bit_realign, attached by bind.
// Tracks beat position within each result to judge first and last beats.
module resp_bit_realign_chk #(
    parameter int SEARCH_BYTES = 8,
    parameter int OUT_BYTES    = 6,
    localparam int OFF_W       = $clog2(SEARCH_BYTES) + 3,
    localparam int BC_W        = $clog2(OUT_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             out_miss,
    input logic [OFF_W-1:0] out_offset
);

    logic            first_q;
    logic [BC_W-1:0] beats_q;

    // Position of the next beat within the current result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            beats_q <= '0;
        end else if (out_valid && out_ready) begin
            first_q <= out_last;
            beats_q <= out_last ? '0 : beats_q + 1'b1;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)
                                    && $stable(out_miss) && $stable(out_offset)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R7

    AST_MISS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_miss |-> out_last && out_data == 8'hFF); // R6

    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && first_q && !out_miss |-> !out_data[7]); // R3

    AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_miss |-> out_last == (beats_q == BC_W'(OUT_BYTES - 1))); // R5

endmodule

bind resp_bit_realign resp_bit_realign_chk #(
    .SEARCH_BYTES (SEARCH_BYTES),
    .OUT_BYTES    (OUT_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_miss   (out_miss),
    .out_offset (out_offset)
);

// File: tb/resp_bit_realign_test.sv
// Sweeps every start offset and the miss case under three traffic modes,
// with expected bytes computed from a bit-level model of the capture.
module resp_bit_realign_test;

    localparam int SB = 8;
    localparam int OB = 6;
    localparam int CB = SB + OB;
    localparam int NBITS = CB * 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_miss;
    logic [5:0] out_offset;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] drv_rs = 32'h1234_5678;
    logic [31:0] rcv_rs = 32'h9e37_79b9;
    logic [31:0] dat_rs = 32'h0bad_cafe;

    logic [7:0] cap_b [CB];
    logic [7:0] exp_b [OB];
    int         n_exp;
    int         exp_off;
    bit         exp_miss;
    bit         stall_seen;

    resp_bit_realign #(.SEARCH_BYTES(SB), .OUT_BYTES(OB)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_miss   (out_miss),
        .out_offset (out_offset)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] v;
        v = x ^ (x << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Build one capture: ones before the start bit, zero at it, then data
    task automatic build(input int off, input bit miss, input bit zero_tail);
        logic bits [NBITS];
        int   resp_end;
        resp_end = miss ? SB * 8 : off + 8 * OB;
        for (int i = 0; i < NBITS; i++) begin
            dat_rs = xs(dat_rs);
            if (miss ? (i < SB * 8) : (i < off)) bits[i] = 1'b1;
            else if (!miss && i == off)           bits[i] = 1'b0;
            else if (zero_tail && i >= resp_end)  bits[i] = 1'b0;
            else                                  bits[i] = dat_rs[7];
        end
        for (int b = 0; b < CB; b++)
            for (int m = 0; m < 8; m++) cap_b[b][7-m] = bits[8*b+m];
        exp_miss = miss;
        if (miss) begin
            n_exp    = 1;
            exp_off  = 0;
            exp_b[0] = 8'hFF;
        end else begin
            n_exp   = OB;
            exp_off = off;
            for (int j = 0; j < OB; j++)
                for (int m = 0; m < 8; m++) exp_b[j][7-m] = bits[off+8*j+m];
        end
    endtask

    // Feed the capture bytes, with random idle cycles in mode 1
    task automatic drive_capture(input int mode);
        bit took;
        stall_seen = 1'b0;
        for (int i = 0; i < CB; i++) begin
            drv_rs = xs(drv_rs);
            if (mode == 1 && drv_rs[3]) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = cap_b[i];
            do begin
                #2;
                took = in_ready;
                if (!took) stall_seen = 1'b1;
                @(negedge clk);
            end while (!took);
        end
        in_valid = 1'b0;
    endtask

    // Collect and check the expected beats, stalling per mode
    task automatic receive(input int mode, input string otag);
        int         j = 0;
        bit         held = 1'b0;
        logic [7:0] held_d = '0;
        string      dtag;
        dtag = exp_miss ? "R6 miss data" : (mode == 0 ? "R3 data" : "R8 data under stalls");
        while (j < n_exp) begin
            rcv_rs = xs(rcv_rs);
            if (mode == 0)      out_ready = 1'b1;
            else if (mode == 1) out_ready = rcv_rs[5];
            else                out_ready = (rcv_rs[6:5] == 2'b00);
            #2;
            if (held) check(out_valid && out_data == held_d, "R7 held beat", {24'd0, out_data},
                            {24'd0, held_d});
            held = 1'b0;
            if (out_valid && !out_ready) begin
                check(!in_ready, "R7 in_ready low while stalled", 32'(in_ready), 32'd0);
                held   = 1'b1;
                held_d = out_data;
            end
            if (out_valid && out_ready) begin
                check(out_data == exp_b[j], dtag, {24'd0, out_data}, {24'd0, exp_b[j]});
                check(int'(out_offset) == exp_off, otag, 32'(out_offset), 32'(exp_off));
                check(out_last == (j == n_exp - 1), "R5 last flag", 32'(out_last),
                      32'(j == n_exp - 1));
                check(out_miss == exp_miss, "R6 miss flag", 32'(out_miss), 32'(exp_miss));
                if (j == 0 && !exp_miss)
                    check(!out_data[7], "R3 start bit in bit 7", 32'(out_data[7]), 32'd0);
                j++;
            end
            @(negedge clk);
        end
        out_ready = 1'b1;
    endtask

    task automatic run_case(input int off, input bit miss, input bit zero_tail,
                            input int mode, input string otag);
        build(off, miss, zero_tail);
        fork
            drive_capture(mode);
            receive(mode, otag);
        join
        if (mode == 0)
            check(!stall_seen, "R9 in_ready stayed high", 32'(stall_seen), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = 8'h00;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(!out_valid, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready, "R1 in_ready after reset", 32'(in_ready), 32'd1);
        @(negedge clk);

        for (int mode = 0; mode < 3; mode++) begin
            for (int off = 0; off < SB * 8; off++)
                run_case(off, 1'b0, 1'b0, mode, "R2 offset");
            run_case(0, 1'b1, 1'b0, mode, "R6 miss offset");
        end

        // R4: discarded tails full of zeros must not start the next search early
        run_case(0, 1'b0, 1'b1, 0, "R2 offset");
        run_case(37, 1'b0, 1'b0, 0, "R4 offset after zero tail");
        run_case(0, 1'b1, 1'b1, 1, "R6 miss offset");
        run_case(63, 1'b0, 1'b0, 1, "R4 offset after miss with zero tail");
        run_case(9, 1'b0, 1'b1, 2, "R2 offset");
        run_case(1, 1'b0, 1'b0, 2, "R4 offset after zero tail");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule